// File: doc/BRIEF.md
# Load Protection Alias Checker

This block lets a scheduler hoist loads above older stores without losing memory ordering. When a hoisted load executes, it claims one protection entry. The entry records the load's start address and its access width. When a store that is older in program order executes, it presents its own address and width together with a mask that names the entries it must be checked against. If the byte range of the store overlaps any selected, live entry, the block raises an alias exception. The runtime then discards the speculative work and re-executes it in a safe order.

The store check is registered. The exception and the index of the lowest conflicting entry appear in the cycle after the store is presented. A clear input is pulsed when a speculative region commits or rolls back, and it frees every entry at once.

Top module: `load_alias_checker`

## Requirements
- R1: After reset every entry is invalid, `alias_o` is 0 and `alias_idx_o` is 0. A store with a full mask before any protect raises no exception.
- R2: A protect with `prot_valid_i` high writes entry `prot_idx_i` with the given address and size and marks it valid. Protecting an index that is already valid replaces its old contents.
- R3: The size code is a 2-bit field: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. It applies to both protect and store ports.
- R4: A store aliases an entry when the ranges [store_addr, store_addr+store_bytes) and [entry_addr, entry_addr+entry_bytes) share at least one byte. Ranges that only touch end-to-start do not alias.
- R5: Bit i of `st_mask_i` selects entry i. Only entries that are both valid and selected take part in the check.
- R6: `alias_o` is high for exactly the one cycle after a cycle in which `st_valid_i` was high and at least one selected entry overlapped. Otherwise it is low.
- R7: With `alias_o`, `alias_idx_o` gives the lowest-numbered overlapping entry. `alias_idx_o` is 0 whenever `alias_o` is low.
- R8: `clear_i` invalidates every entry. When a protect arrives in the same cycle as `clear_i`, the clear wins and the entry is left invalid.
- R9: A store in the same cycle as a protect or a clear is checked against the entry contents from before that cycle's update.
- R10: Byte ranges do not wrap at the top of the address space. An entry ending at 0xFFFFFFFF does not alias a store at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prot_valid_i | input | 1 | Protect request this cycle |
| prot_idx_i | input | 3 | Entry to write |
| prot_addr_i | input | 32 | Start address of the protected load |
| prot_size_i | input | 2 | Size code of the protected load |
| st_valid_i | input | 1 | Checked store this cycle |
| st_addr_i | input | 32 | Store start address |
| st_size_i | input | 2 | Store size code |
| st_mask_i | input | 8 | Entries the store is checked against |
| clear_i | input | 1 | Invalidate all entries |
| alias_o | output | 1 | Alias exception, one cycle after the store |
| alias_idx_o | output | 3 | Lowest overlapping entry, 0 when no exception |

## Verification
The assertions assume that `st_valid_i`, `prot_valid_i` and `clear_i` are low throughout reset. They also assume that inputs change only away from the rising edge, so the cycle after reset never inherits a stale store. The stimulus drives every input on the falling edge and holds all valids low during reset. Directed stimulus covers size boundaries, touching ranges, masking, the top of the address space and same-cycle collisions. A random phase then confines addresses to a 64-byte window so that overlaps are frequent, and a cycle-level model predicts each output.

// File: rtl/lac_pkg.sv
package lac_pkg;

  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } size_e;

endpackage

// File: rtl/lac_entry.sv
module lac_entry #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  lac_pkg::size_e    wr_size_i,
  input  logic              chk_en_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  lac_pkg::size_e    chk_size_i,
  output logic              hit_o
);
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  lac_pkg::size_e    size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      size_q  <= lac_pkg::SZ_1B;
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      addr_q  <= wr_addr_i;
      size_q  <= wr_size_i;
    end
  end

  // Extended-width bounds keep ranges from wrapping at the top
  logic [EXT_W-1:0] e_lo, e_hi, s_lo, s_hi;
  always_comb begin
    e_lo  = {1'b0, addr_q};
    e_hi  = e_lo + (EXT_W'(1) << size_q);
    s_lo  = {1'b0, chk_addr_i};
    s_hi  = s_lo + (EXT_W'(1) << chk_size_i);
    hit_o = chk_en_i && valid_q && (s_lo < e_hi) && (e_lo < s_hi);
  end

  // R8
  clear_kills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> !valid_q);

  // R2
  write_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && !clear_i) |-> (valid_q && addr_q == $past(wr_addr_i)));

endmodule

// File: rtl/lac_prio.sv
module lac_prio #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  // R7
  always_comb begin
    lowest_sel_chk: assert (!found_o || (req_i[idx_o] &&
      ((req_i & ~({N{1'b1}} << idx_o)) == '0)));
  end

endmodule

// File: rtl/load_alias_checker.sv
module load_alias_checker #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned ADDR_W      = 32,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   prot_valid_i,
  input  logic [IDX_W-1:0]       prot_idx_i,
  input  logic [ADDR_W-1:0]      prot_addr_i,
  input  logic [1:0]             prot_size_i,
  input  logic                   st_valid_i,
  input  logic [ADDR_W-1:0]      st_addr_i,
  input  logic [1:0]             st_size_i,
  input  logic [NUM_ENTRIES-1:0] st_mask_i,
  input  logic                   clear_i,
  output logic                   alias_o,
  output logic [IDX_W-1:0]       alias_idx_o
);
  logic [NUM_ENTRIES-1:0] hit;
  logic                   found;
  logic [IDX_W-1:0]       found_idx;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    lac_entry #(.ADDR_W(ADDR_W)) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (clear_i),
      .wr_i       (prot_valid_i && (prot_idx_i == IDX_W'(g))),
      .wr_addr_i  (prot_addr_i),
      .wr_size_i  (lac_pkg::size_e'(prot_size_i)),
      .chk_en_i   (st_valid_i && st_mask_i[g]),
      .chk_addr_i (st_addr_i),
      .chk_size_i (lac_pkg::size_e'(st_size_i)),
      .hit_o      (hit[g])
    );
  end

  lac_prio #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_prio (
    .req_i   (hit),
    .found_o (found),
    .idx_o   (found_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alias_o     <= 1'b0;
      alias_idx_o <= '0;
    end else begin
      alias_o     <= found;
      alias_idx_o <= found ? found_idx : '0;
    end
  end

  // R6
  no_store_no_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(st_valid_i) |-> !alias_o);

  // R7
  idx_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alias_o |-> (alias_idx_o == '0));

  // R5
  idx_was_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_o |-> |($past(st_mask_i) & (NUM_ENTRIES'(1) << alias_idx_o)));

endmodule

// File: tb/load_alias_checker_tb.sv
module load_alias_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pv = 1'b0;
  logic [2:0]  pidx = '0;
  logic [31:0] paddr = '0;
  logic [1:0]  psz = '0;
  logic        sv = 1'b0;
  logic [31:0] saddr = '0;
  logic [1:0]  ssz = '0;
  logic [7:0]  smask = '0;
  logic        clr = 1'b0;
  logic        alias_o;
  logic [2:0]  alias_idx_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  load_alias_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .prot_valid_i(pv), .prot_idx_i(pidx), .prot_addr_i(paddr), .prot_size_i(psz),
    .st_valid_i(sv), .st_addr_i(saddr), .st_size_i(ssz), .st_mask_i(smask),
    .clear_i(clr), .alias_o(alias_o), .alias_idx_o(alias_idx_o)
  );

  // behavioural model
  bit      m_v [8];
  longint  m_a [8];
  int      m_s [8];
  bit      exp_a = 1'b0;
  int      exp_i = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) begin m_v[k] = 0; m_a[k] = 0; m_s[k] = 1; end
      exp_a = 0; exp_i = 0;
    end else begin
      bit a; int ix; longint slo, shi;
      a = 0; ix = 0;
      slo = longint'(saddr); shi = slo + (longint'(1) << ssz);
      if (sv) begin
        for (int k = 7; k >= 0; k--)
          if (smask[k] && m_v[k] && slo < m_a[k] + m_s[k] && m_a[k] < shi) begin
            a = 1; ix = k;
          end
      end
      exp_a = a; exp_i = a ? ix : 0;
      if (clr) begin
        for (int k = 0; k < 8; k++) m_v[k] = 0;
      end else if (pv) begin
        m_v[pidx] = 1; m_a[pidx] = longint'(paddr); m_s[pidx] = 1 << psz;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (alias_o !== exp_a || int'(alias_idx_o) != exp_i) begin
        fails++;
        $display("FAIL %s: alias=%0b idx=%0d expected alias=%0b idx=%0d",
                 tag, alias_o, alias_idx_o, exp_a, exp_i);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic drive(input bit p, input int pi, input longint pa, input int ps,
                       input bit s, input longint sa, input int ss, input int sm,
                       input bit c);
    pv = p; pidx = 3'(pi); paddr = 32'(pa); psz = 2'(ps);
    sv = s; saddr = 32'(sa); ssz = 2'(ss); smask = 8'(sm); clr = c;
    @(negedge clk);
    pv = 0; sv = 0; clr = 0;
  endtask

  task automatic prot(input int pi, input longint pa, input int ps);
    drive(1, pi, pa, ps, 0, 0, 0, 0, 0);
  endtask

  task automatic st(input longint sa, input int ss, input int sm);
    drive(0, 0, 0, 0, 1, sa, ss, sm, 0);
    @(negedge clk);
  endtask

  task automatic clear_all();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state and empty table
    tag = "R1";
    tests++;
    if (alias_o !== 1'b0 || alias_idx_o !== 3'd0) begin
      fails++;
      $display("FAIL R1: alias=%0b idx=%0d expected 0 0", alias_o, alias_idx_o);
    end
    st(32'h100, 3, 8'hFF);
    // R2: protect then hit; overwrite moves the region
    tag = "R2";
    prot(2, 32'h1000, 2);
    st(32'h1002, 0, 8'hFF);
    prot(2, 32'h2000, 2);
    st(32'h1000, 2, 8'hFF);
    st(32'h2003, 0, 8'hFF);
    // R3: size codes at their last and first-outside bytes
    tag = "R3";
    clear_all();
    prot(0, 32'h3000, 0);
    prot(1, 32'h3010, 1);
    prot(3, 32'h3020, 3);
    st(32'h3001, 0, 8'h01);
    st(32'h3011, 0, 8'h02);
    st(32'h3012, 0, 8'h02);
    st(32'h3027, 0, 8'h08);
    st(32'h3028, 0, 8'h08);
    // R4: touching ranges and partial overlap
    tag = "R4";
    st(32'h301C, 2, 8'h08);
    st(32'h301D, 2, 8'h08);
    st(32'h300E, 1, 8'h02);
    // R5: mask and validity
    tag = "R5";
    st(32'h3020, 3, 8'hF7);
    st(32'h5000, 0, 8'hFF);
    // R7: lowest of several
    tag = "R7";
    prot(6, 32'h4000, 3);
    prot(4, 32'h4004, 2);
    prot(5, 32'h4002, 0);
    st(32'h4000, 3, 8'hFF);
    st(32'h4000, 3, 8'hC0);
    // R8: clear, and clear beats a same-cycle protect
    tag = "R8";
    clear_all();
    st(32'h4000, 3, 8'hFF);
    drive(1, 7, 32'h6000, 3, 0, 0, 0, 0, 1);
    st(32'h6000, 3, 8'hFF);
    // R9: store sees contents before same-cycle update
    tag = "R9";
    drive(1, 1, 32'h7000, 2, 1, 32'h7000, 2, 8'hFF, 0);
    @(negedge clk);
    st(32'h7000, 2, 8'hFF);
    drive(0, 0, 0, 0, 1, 32'h7001, 0, 8'hFF, 1);
    @(negedge clk);
    st(32'h7001, 0, 8'hFF);
    // R10: no wrap at top of address space
    tag = "R10";
    prot(0, 32'hFFFF_FFF8, 3);
    st(32'h0, 3, 8'hFF);
    st(32'hFFFF_FFFF, 0, 8'hFF);
    // R6: back-to-back and random mix in a small window
    tag = "R6";
    for (int n = 0; n < 2000; n++) begin
      drive(($urandom % 3) == 0, $urandom % 8, 32'h8000 + ($urandom % 64), $urandom % 4,
            ($urandom % 2) == 0, 32'h8000 + ($urandom % 64), $urandom % 4, $urandom % 256,
            ($urandom % 29) == 0);
    end
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule